// File: doc/BRIEF.md
# Twin-Plane Product-Term Logic Block

This block is a small programmable logic cell. Twenty-four inputs are each used in true and in complement form, and they feed one array of AND product terms. Two planes of OR/XOR logic read that array. Each plane serves four of the eight outputs. A static configuration word sets which literals each product term uses, which terms each output sums, the output polarity and the register behaviour. The word is captured while a load strobe is high and is then held.

Each output can take one of two paths. The wide path ORs any subset of its plane's twenty pool terms and then applies an XOR stage. The fast path ORs a fixed group of four terms with no XOR stage. The result can go straight to the pin, or through a register. That register is clocked by the rising edge of one of three global clock lines, or by the plane's own clock product term. A reset product term per plane can clear chosen registers. An enable product term per plane can drive that plane's output-enable line. All timing is in one system clock domain. Clock lines and product-term clocks act as edge-detected load enables.

Top module: `plb_twin_block`

## Requirements
- R1: A product term is the AND of every literal it selects. A term whose enable bit is 0 is 0 whatever it selects. An enabled term that selects no literal is 1.
- R2: On the wide path, an output is the OR of the pool terms set in its 20-bit sum mask, XORed by its XOR mode. The modes are: 0 = constant 0, 1 = constant 1 (inverted), 2 = the output's XOR term, 3 = the complement of that term.
- R3: On the fast path, output k ORs pool terms 4*(k mod 4) to 4*(k mod 4)+3 of its plane. Its sum mask and XOR mode have no effect.
- R4: An output in combinational mode shows its logic value in the same cycle that the inputs change.
- R5: A registered output loads its logic value at a system-clock edge only when the selected global clock line is 1 after having been 0 at the previous edge. At all other edges it holds. Clock select codes 0, 1 and 2 pick global lines 0, 1 and 2.
- R6: Clock select code 3 uses the rising edge of the plane's clock product term in the same way.
- R7: When an output's reset-enable bit is set and its plane's reset term is 1 at an edge, the register clears to 0. This wins over a load in the same cycle.
- R8: The active-low asynchronous reset clears all eight registers, the edge history and the stored configuration. After reset every output is 0 and both enables are 1.
- R9: If a plane's enable-use bit is set, its output-enable line follows the plane's enable term. Otherwise that line is 1.
- R10: The configuration word is captured only at edges where the load strobe is 1. Changes to the word at other times have no effect.
- R11: Word layout. Product term j takes 49 bits from bit 49*j: bit 0 is the enable, the next 24 bits are the true literals of inputs 0-23, and the next 24 bits are the complement literals. Plane p owns terms 27p to 27p+26: 20 pool terms, then one XOR term per local output, then its clock, reset and enable terms. Output k's record starts at bit 2646+27k: sum mask [19:0], fast bit 20, XOR mode [22:21], registered bit 23, clock select [25:24], reset enable bit 26. Bit 2862+p is plane p's enable-use bit.
- R12: Outputs of plane 1 use only plane 1 terms. Plane 0 terms never reach them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Configuration capture strobe |
| cfgData | input | 2864 | Configuration word |
| dataIn | input | 24 | Logic inputs |
| gclk | input | 3 | Global clock lines, sampled synchronously |
| dataOut | output | 8 | Output values |
| oeOut | output | 2 | Per-plane output enables |

## Verification
The assertions assume that the configuration word changes only through the load strobe. They also assume that the clock lines and inputs are synchronous to the system clock, so a sampled level of 0 followed by 1 is one clean rising edge. They further assume that reset stays low across at least one system-clock edge. The stimulus drives every input on the falling edge. It holds the load strobe low during normal operation and changes the configuration word only while the strobe is low. It drives inputs to 0 before it pulls reset low, and it keeps reset low for a full cycle.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int NumIn       = 24;
  localparam int NumPlane    = 2;
  localparam int OutPerPlane = 4;
  localparam int NumOut      = NumPlane * OutPerPlane;
  localparam int PoolSize    = 20;
  localparam int FastTerms   = 4;
  localparam int NumGclk     = 3;
  localparam int ClkSelW     = $clog2(NumGclk + 1);

  // product-term bookkeeping per plane: pool, one xor term per output, clock, reset, enable
  localparam int ClkPtOff   = PoolSize + OutPerPlane;
  localparam int RstPtOff   = ClkPtOff + 1;
  localparam int OePtOff    = ClkPtOff + 2;
  localparam int PtPerPlane = PoolSize + OutPerPlane + 3;
  localparam int NumPt      = NumPlane * PtPerPlane;
  localparam int PtW        = 1 + 2 * NumIn;

  // output record fields
  localparam int FastBit = PoolSize;
  localparam int XorLo   = PoolSize + 1;
  localparam int CombW   = PoolSize + 3;
  localparam int RegBit  = PoolSize + 3;
  localparam int ClkLo   = PoolSize + 4;
  localparam int RstBit  = ClkLo + ClkSelW;
  localparam int OutW    = RstBit + 1;

  localparam int OutBase   = NumPt * PtW;
  localparam int PlaneBase = OutBase + NumOut * OutW;
  localparam int CfgW      = PlaneBase + NumPlane;

  typedef enum logic [1:0] {
    XOR_ZERO   = 2'd0,
    XOR_ONE    = 2'd1,
    XOR_TERM   = 2'd2,
    XOR_TERM_N = 2'd3
  } xorMode_t;

  typedef struct packed {
    logic [NumOut-1:0] load;
    logic [NumOut-1:0] clear;
  } plbStrobe_t;
endpackage

// File: rtl/plb_cfg_store.sv
module plb_cfg_store
  import plb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic [CfgW-1:0] cfgData,
  output logic [CfgW-1:0] cfgQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= '0;
    else if (cfgLoad) cfgQ <= cfgData;
  end
endmodule

// File: rtl/plb_datapath.sv
module plb_datapath
  import plb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [OutBase-1:0]        ptCfg,
  input  logic [NumOut*CombW-1:0]   combCfg,
  input  logic [NumIn-1:0]          dataIn,
  input  plbStrobe_t                strobe,
  output logic [NumOut-1:0]         combVal,
  output logic [NumOut-1:0]         regQ,
  output logic [NumPlane-1:0]       ptClkLvl,
  output logic [NumPlane-1:0]       ptRstLvl,
  output logic [NumPlane-1:0]       ptOeLvl
);
  logic [NumPt-1:0] term;

  // shared AND array
  for (genvar j = 0; j < NumPt; j++) begin : g_pt
    logic [PtW-1:0] pc;
    logic [NumIn-1:0] useTrue, useComp;
    assign pc      = ptCfg[j*PtW +: PtW];
    assign useTrue = pc[1 +: NumIn];
    assign useComp = pc[1+NumIn +: NumIn];
    assign term[j] = pc[0] & (&((~useTrue | dataIn) & (~useComp | ~dataIn)));
  end

  // per-plane control terms
  for (genvar p = 0; p < NumPlane; p++) begin : g_plane
    assign ptClkLvl[p] = term[p*PtPerPlane + ClkPtOff];
    assign ptRstLvl[p] = term[p*PtPerPlane + RstPtOff];
    assign ptOeLvl[p]  = term[p*PtPerPlane + OePtOff];
  end

  // OR/XOR planes and fast bypass
  for (genvar k = 0; k < NumOut; k++) begin : g_out
    localparam int Plane = k / OutPerPlane;
    localparam int Local = k % OutPerPlane;
    localparam int Base  = Plane * PtPerPlane;
    logic [CombW-1:0]    oc;
    logic [PoolSize-1:0] pool;
    logic sumV, fastV, xorTerm, xorV;
    assign oc      = combCfg[k*CombW +: CombW];
    assign pool    = term[Base +: PoolSize];
    assign xorTerm = term[Base + PoolSize + Local];
    assign sumV    = |(pool & oc[PoolSize-1:0]);
    assign fastV   = |pool[Local*FastTerms +: FastTerms];
    always_comb begin
      unique case (xorMode_t'(oc[XorLo +: 2]))
        XOR_ZERO:   xorV = 1'b0;
        XOR_ONE:    xorV = 1'b1;
        XOR_TERM:   xorV = xorTerm;
        XOR_TERM_N: xorV = ~xorTerm;
        default:    xorV = 1'b0;
      endcase
    end
    assign combVal[k] = oc[FastBit] ? fastV : (sumV ^ xorV);
  end

  // output registers: clear wins over load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else regQ <= (regQ & ~(strobe.load | strobe.clear))
               | (combVal & strobe.load & ~strobe.clear);
  end
endmodule

// File: rtl/plb_control.sv
module plb_control
  import plb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumGclk-1:0]        gclk,
  input  logic [NumPlane-1:0]       ptClkLvl,
  input  logic [NumPlane-1:0]       ptRstLvl,
  input  logic [NumOut*ClkSelW-1:0] clkSel,
  input  logic [NumOut-1:0]         rstEn,
  output plbStrobe_t                strobe
);
  logic [NumGclk-1:0]  gclkPrev, gRise;
  logic [NumPlane-1:0] ptClkPrev, pRise;
  logic [NumOut-1:0]   loadVec, clearVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gclkPrev  <= '0;
      ptClkPrev <= '0;
    end else begin
      gclkPrev  <= gclk;
      ptClkPrev <= ptClkLvl;
    end
  end

  assign gRise = gclk & ~gclkPrev;
  assign pRise = ptClkLvl & ~ptClkPrev;

  for (genvar k = 0; k < NumOut; k++) begin : g_sel
    localparam int Plane = k / OutPerPlane;
    logic [NumGclk:0] src;
    assign src         = {pRise[Plane], gRise};
    assign loadVec[k]  = src[clkSel[k*ClkSelW +: ClkSelW]];
    assign clearVec[k] = rstEn[k] & ptRstLvl[Plane];
  end

  assign strobe = '{load: loadVec, clear: clearVec};
endmodule

// File: rtl/plb_twin_block.sv
module plb_twin_block
  import plb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [CfgW-1:0]     cfgData,
  input  logic [NumIn-1:0]    dataIn,
  input  logic [NumGclk-1:0]  gclk,
  output logic [NumOut-1:0]   dataOut,
  output logic [NumPlane-1:0] oeOut
);
  logic [CfgW-1:0]             cfgQ;
  logic [NumOut*CombW-1:0]     combCfg;
  logic [NumOut*ClkSelW-1:0]   clkSel;
  logic [NumOut-1:0]           rstEn, regMode, combVal, regQ;
  logic [NumPlane-1:0]         ptClkLvl, ptRstLvl, ptOeLvl;
  plbStrobe_t                  strobe;

  plb_cfg_store u_cfg (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgData(cfgData), .cfgQ(cfgQ)
  );

  for (genvar k = 0; k < NumOut; k++) begin : g_rec
    logic [OutW-1:0] rec;
    assign rec                          = cfgQ[OutBase + k*OutW +: OutW];
    assign combCfg[k*CombW +: CombW]    = rec[CombW-1:0];
    assign regMode[k]                   = rec[RegBit];
    assign clkSel[k*ClkSelW +: ClkSelW] = rec[ClkLo +: ClkSelW];
    assign rstEn[k]                     = rec[RstBit];
    assign dataOut[k]                   = regMode[k] ? regQ[k] : combVal[k];
  end

  for (genvar p = 0; p < NumPlane; p++) begin : g_oe
    assign oeOut[p] = cfgQ[PlaneBase + p] ? ptOeLvl[p] : 1'b1;
  end

  plb_control u_ctl (
    .clk(clk), .rstN(rstN), .gclk(gclk), .ptClkLvl(ptClkLvl), .ptRstLvl(ptRstLvl),
    .clkSel(clkSel), .rstEn(rstEn), .strobe(strobe)
  );

  plb_datapath u_dp (
    .clk(clk), .rstN(rstN), .ptCfg(cfgQ[OutBase-1:0]), .combCfg(combCfg),
    .dataIn(dataIn), .strobe(strobe), .combVal(combVal), .regQ(regQ),
    .ptClkLvl(ptClkLvl), .ptRstLvl(ptRstLvl), .ptOeLvl(ptOeLvl)
  );
endmodule

// File: rtl/plb_twin_block_chk.sv
module plb_twin_block_chk
  import plb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [CfgW-1:0]   cfgQ,
  input plbStrobe_t        strobe,
  input logic [NumOut-1:0] regQ,
  input logic [NumOut-1:0] combVal
);
  // R10: stored word only moves on a load cycle
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(cfgQ));

  for (genvar k = 0; k < NumOut; k++) begin : g_k
    // R5: no strobe, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.load[k] || strobe.clear[k]) |=> $stable(regQ[k]));
    // R5: load captures the logic value of that cycle
    a_r5_load: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load[k] && !strobe.clear[k]) |=> (regQ[k] == $past(combVal[k])));
    // R7: clear always leaves zero, even alongside a load
    a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clear[k] |=> !regQ[k]);
  end
endmodule

bind plb_twin_block plb_twin_block_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgQ(cfgQ),
  .strobe(strobe), .regQ(regQ), .combVal(combVal)
);

// File: tb/tb_plb_twin_block.sv
module tb_plb_twin_block;
  import plb_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [CfgW-1:0] cfgData = '0;
  logic [CfgW-1:0] cv = '0;
  logic [NumIn-1:0] dataIn = '0;
  logic [NumGclk-1:0] gclk = '0;
  logic [NumOut-1:0] dataOut;
  logic [NumPlane-1:0] oeOut;

  always #5 clk = ~clk;

  plb_twin_block dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgData(cfgData),
    .dataIn(dataIn), .gclk(gclk), .dataOut(dataOut), .oeOut(oeOut)
  );

  typedef struct { string tag; logic [7:0] data; logic [1:0] oe; } exp_t;
  exp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // requirement model state
  bit q3 = 0, q5 = 0, q6 = 0, prevPt = 0, cfgOn = 0;
  logic [2:0] prevG = '0;

  // R11 layout helpers
  task automatic setPt(input int idx, input logic [23:0] tMask, input logic [23:0] cMask);
    cv[idx*49] = 1'b1;
    cv[idx*49 + 1 +: 24] = tMask;
    cv[idx*49 + 25 +: 24] = cMask;
  endtask

  task automatic setOut(input int k, input logic [19:0] mask, input bit fast,
                        input logic [1:0] xm, input bit isReg, input logic [1:0] cs, input bit re);
    int b;
    b = 2646 + 27*k;
    cv[b +: 20] = mask;
    cv[b + 20] = fast;
    cv[b + 21 +: 2] = xm;
    cv[b + 23] = isReg;
    cv[b + 24 +: 2] = cs;
    cv[b + 26] = re;
  endtask

  // scoreboard driver
  task automatic step(input logic [23:0] din, input logic [2:0] g, input string tag);
    exp_t e;
    logic [7:0] d;
    @(negedge clk);
    dataIn = din;
    gclk = g;
    if (cfgOn) begin
      d[0] = ((din[0] & din[1]) | ~din[2]) ^ din[6];
      d[1] = din[5];
      d[2] = 1'b0;
      d[3] = q3;
      d[4] = 1'b1;
      d[5] = q5;
      d[6] = q6;
      d[7] = ~din[11];
      e.oe = {1'b1, din[9]};
    end else begin
      d = '0;
      e.oe = 2'b11;
    end
    e.tag = tag;
    e.data = d;
    expQ.push_back(e);
    if (cfgOn) begin
      if (din[8]) q3 = 0;
      else if (g[0] && !prevG[0]) q3 = ~(din[3] & ~din[4]);
      if (din[10] && !prevPt) q5 = din[0];
      if (g[2] && !prevG[2]) q6 = din[0];
      prevPt = din[10];
    end else begin
      prevPt = 0;
    end
    prevG = g;
  endtask

  task automatic loadCfg();
    @(negedge clk);
    cfgData = cv;
    cfgLoad = 1'b1;
    dataIn = '0;
    gclk = '0;
    prevG = '0;
    prevPt = 0;
    @(negedge clk);
    cfgLoad = 1'b0;
    cfgData = ~cv;
    cfgOn = 1;
  endtask

  task automatic resetPulse();
    @(negedge clk);
    dataIn = '0;
    gclk = '0;
    #3 rstN = 1'b0;
    @(negedge clk);
    #3 rstN = 1'b1;
    q3 = 0; q5 = 0; q6 = 0;
    prevG = '0; prevPt = 0; cfgOn = 0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (dataOut !== e.data || oeOut !== e.oe) begin
          fails++;
          $display("FAIL %s: dataOut=%b oeOut=%b expected dataOut=%b oeOut=%b",
                   e.tag, dataOut, oeOut, e.data, e.oe);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // configuration A (R11 layout)
    setPt(0, 24'h000003, 24'h0);    // in0 & in1
    setPt(1, 24'h0, 24'h000004);    // ~in2
    setPt(3, 24'h000008, 24'h000010); // in3 & ~in4
    setPt(4, 24'h000020, 24'h0);    // in5, fast group of output 1
    setPt(20, 24'h000040, 24'h0);   // xor term of output 0
    setPt(24, 24'h000080, 24'h0);   // plane 0 clock term
    setPt(25, 24'h000100, 24'h0);   // plane 0 reset term: in8
    setPt(26, 24'h000200, 24'h0);   // plane 0 enable term: in9
    setPt(27, 24'h0, 24'h0);        // enabled, empty -> 1
    setPt(28, 24'h000001, 24'h0);   // in0
    setPt(50, 24'h000800, 24'h0);   // xor term of output 7
    setPt(51, 24'h000400, 24'h0);   // plane 1 clock term: in10
    setOut(0, 20'h00003, 0, 2'd2, 0, 2'd0, 0);
    setOut(1, 20'h00001, 1, 2'd1, 0, 2'd0, 0);
    setOut(2, 20'h00004, 0, 2'd0, 0, 2'd0, 0);
    setOut(3, 20'h00008, 0, 2'd1, 1, 2'd0, 1);
    setOut(4, 20'h00001, 0, 2'd0, 0, 2'd0, 0);
    setOut(5, 20'h00002, 0, 2'd0, 1, 2'd3, 0);
    setOut(6, 20'h00002, 0, 2'd0, 1, 2'd2, 0);
    setOut(7, 20'h00000, 0, 2'd3, 0, 2'd0, 0);
    cv[2862] = 1'b1;

    repeat (3) @(negedge clk);
    #3 rstN = 1'b1;

    step(24'h000FFF, 3'b000, "R8 reset state, empty configuration");
    loadCfg();
    step(24'h000000, 3'b000, "R1 R2 R9 R12 idle pattern (R11 layout)");
    step(24'h000007, 3'b000, "R2 sum of masked terms");
    step(24'h000004, 3'b000, "R2 R4 sum zero");
    step(24'h000044, 3'b000, "R2 xor term applied");
    step(24'h000043, 3'b000, "R2 xor term cancels sum");
    step(24'h000023, 3'b000, "R3 fast path set");
    step(24'h000003, 3'b000, "R3 fast path ignores mask and xor");
    step(24'h000200, 3'b000, "R9 enable term high");
    step(24'h000800, 3'b000, "R2 R12 inverted xor term on plane 1");
    // registered via global line 0
    step(24'h000000, 3'b001, "R5 rise loads");
    step(24'h000008, 3'b001, "R5 level held, no load");
    step(24'h000008, 3'b000, "R5 hold");
    step(24'h000008, 3'b001, "R5 rise loads zero");
    step(24'h000000, 3'b010, "R5 other line has no effect");
    step(24'h000000, 3'b011, "R5 rise loads one");
    step(24'h000000, 3'b000, "R5 observe");
    step(24'h000100, 3'b001, "R7 reset term beats load");
    step(24'h000000, 3'b000, "R7 cleared");
    step(24'h000000, 3'b001, "R7 reload after reset");
    // product-term clock
    step(24'h000001, 3'b000, "R6 no edge");
    step(24'h000401, 3'b000, "R6 term rise loads");
    step(24'h000400, 3'b000, "R6 term held");
    step(24'h000000, 3'b000, "R6 hold");
    step(24'h000400, 3'b000, "R6 rise loads zero");
    step(24'h000001, 3'b000, "R6 observe");
    step(24'h000401, 3'b000, "R6 rise loads one");
    step(24'h000001, 3'b100, "R5 line 2 rise");
    step(24'h000000, 3'b000, "R5 line 2 observe");
    @(negedge clk);
    cfgData = '0;
    step(24'h000000, 3'b000, "R10 word change without load ignored");
    step(24'h000280, 3'b000, "R10 R9 after word change");
    resetPulse();
    step(24'h000000, 3'b000, "R8 configuration cleared");
    loadCfg();
    step(24'h000000, 3'b000, "R8 registers cleared");
    step(24'h000000, 3'b000, "R8 registers still clear");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R4 scoreboard: pending=%0d expected 0", expQ.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule